// File: doc/BRIEF.md
# SD Card Bus Clock Generator

This block derives the card bus clock from the peripheral clock through two cascaded divide stages. The first stage divides by (N+1), where N is a 4-bit field. The second stage is an even prescaler that divides by twice its 12-bit value, and a prescaler of zero bypasses it. Software loads a rate word and writes a control word that carries stop, start and soft-reset strobes. The block drives the card clock, a status word that reports whether the clock is running, and a one-cycle soft-reset pulse for the rest of the controller.

Gating is glitch-free. A stop request lets the current card-clock period finish before the clock parks low. A new rate word waits for the low phase at the end of the current period, so the card never sees a shortened pulse. While the clock is stopped, a new rate is applied at once.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the clock is stopped, the card clock is low, the status word and the soft-reset output are zero, and the active rate is prescaler 0x800 with divider 15. The first start therefore gives a high phase of 32768 input cycles, which is the slowest rate of 1/65536.
- R2: The rate word holds the prescaler in bits [15:4] and the divider in bits [3:0]. With a nonzero prescaler P and divider D, the card clock period is (D+1)*2*P input cycles and the high phase is (D+1)*P cycles.
- R3: A prescaler of zero bypasses the second stage. The period is then D+1 input cycles and the high phase is floor((D+1)/2) cycles, so D=1 gives the fastest rate of 1/2.
- R4: A divider field of 0 is treated as 1. A prescaler field above 0x800 is treated as 0x800.
- R5: The control word uses bit 1 as a start strobe. One cycle after a start is written, bit 8 of the status word (clock running) reads 1. The first card clock high phase has its full length.
- R6: The control word uses bit 0 as a stop strobe. The current card-clock period completes, then bit 8 of the status word falls and the card clock stays low.
- R7: When stop and start are written in the same word, stop wins. A running clock stops, and a stopped clock stays stopped.
- R8: A rate word written while the clock runs takes effect only at the end of the current period, during the low phase. Every high pulse has the full length of either the old rate or the new one.
- R9: Writing bit 3 of the control word raises the soft-reset output for exactly one cycle, starting the cycle after the write. It does not change the running state. Bit 2 of the control word is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rateWr | input | 1 | Write strobe for the rate word |
| rateData | input | 16 | Rate word: prescaler [15:4], divider [3:0] |
| ctrlWr | input | 1 | Write strobe for the control word |
| ctrlData | input | 4 | Control word: bit 0 stop, bit 1 start, bit 3 soft reset |
| cardClk | output | 1 | Gated, divided card bus clock |
| statusWord | output | 16 | Status, bit 8 set while the card clock runs |
| softRst | output | 1 | One-cycle soft-reset pulse |

## Verification
Control strobes register on the write edge. The running flag and the soft-reset pulse are therefore due one cycle after the write, and the bench samples them at the first falling clock edge after that write. The card clock output adds one more register, so its length results are not tied to any fixed cycle. The bench counts the high and low runs of the card clock at falling edges, from one clean rising transition onward, and compares them with the periods computed from R2 to R4. Stop is checked by waiting for the running flag to fall within one period. A monitor checks that every completed high pulse matches one of the rates in force.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  // Strobes and levels passed from control to datapath
  typedef struct packed {
    logic run;   // card clock enabled
    logic load;  // copy pending rate into active rate, restart counters
  } dpCtrl_t;
endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int PRE_W   = 12,
  parameter int PRE_MAX = 2048,
  parameter int RST_DIV = 15,
  parameter int RST_PRE = 2048,
  localparam int RATE_W = PRE_W + DIV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateWr,
  input  logic [RATE_W-1:0] rateData,
  input  logic              ctrlWr,
  input  logic [3:0]        ctrlData,
  input  logic              periodEnd,
  output dpCtrl_t           dpCtrl,
  output logic [DIV_W-1:0]  pendDiv,
  output logic [PRE_W-1:0]  pendPre,
  output logic              running,
  output logic              softRst
);
  logic stopBit, startBit, rstBit;
  logic ctrlUnused;
  logic runQ, stopPend, loadPend, softRstQ;
  logic runD, stopD, loadNow;
  logic [DIV_W-1:0] rawDiv, clampDiv;
  logic [PRE_W-1:0] rawPre, clampPre;

  assign stopBit    = ctrlWr & ctrlData[0];
  assign startBit   = ctrlWr & ctrlData[1];
  assign rstBit     = ctrlWr & ctrlData[3];
  assign ctrlUnused = ctrlData[2];

  // Field extraction and range clamping of the rate word
  assign rawDiv   = rateData[DIV_W-1:0];
  assign rawPre   = rateData[RATE_W-1:DIV_W];
  assign clampDiv = (rawDiv == '0) ? DIV_W'(1) : rawDiv;
  assign clampPre = (rawPre > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : rawPre;

  // A pending rate goes live at once when idle, else at the period boundary
  assign loadNow = loadPend & (~runQ | periodEnd);

  always_comb begin
    runD  = runQ;
    stopD = stopPend;
    if (stopBit) begin
      if (runQ) stopD = 1'b1;
    end else if (startBit) begin
      runD  = 1'b1;
      stopD = 1'b0;
    end
    if (periodEnd && stopD) begin
      runD  = 1'b0;
      stopD = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      stopPend <= 1'b0;
      loadPend <= 1'b0;
      softRstQ <= 1'b0;
      pendDiv  <= DIV_W'(RST_DIV);
      pendPre  <= PRE_W'(RST_PRE);
    end else begin
      runQ     <= runD;
      stopPend <= stopD;
      softRstQ <= rstBit;
      if (rateWr) begin
        pendDiv  <= clampDiv;
        pendPre  <= clampPre;
        loadPend <= 1'b1;
      end else if (loadNow) begin
        loadPend <= 1'b0;
      end
    end
  end

  assign dpCtrl.run  = runQ;
  assign dpCtrl.load = loadNow;
  assign running     = runQ;
  assign softRst     = softRstQ;

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && ctrlData[0] && ctrlData[1] && !runQ) |=> !runQ);  // R7
  AST_SOFTRST_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(softRstQ) |-> $past(ctrlWr && ctrlData[3]));  // R9
  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runQ) |-> $past(periodEnd));  // R6
endmodule

// File: rtl/sdclk_dp.sv
module sdclk_dp
  import sdclk_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int PRE_W   = 12,
  parameter int PRE_MAX = 2048,
  parameter int RST_DIV = 15,
  parameter int RST_PRE = 2048,
  localparam int PCNT_W = $clog2(2 * PRE_MAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [DIV_W-1:0] newDiv,
  input  logic [PRE_W-1:0] newPre,
  output logic             cardClk,
  output logic             periodEnd
);
  logic [DIV_W-1:0]  actDiv, divCnt;
  logic [PRE_W-1:0]  actPre;
  logic [PCNT_W-1:0] preCnt;
  logic [PCNT_W:0]   preTwice, preLast;
  logic [DIV_W:0]    divPlus1, halfDiv;
  logic              bypass, divWrap, preWrap, phaseHigh, cardClkQ;

  assign bypass   = (actPre == '0);
  assign divWrap  = (divCnt == actDiv);
  assign preTwice = (PCNT_W+1)'(actPre) << 1;
  assign preLast  = preTwice - (PCNT_W+1)'(1);
  assign preWrap  = ((PCNT_W+1)'(preCnt) == preLast);
  assign divPlus1 = (DIV_W+1)'(actDiv) + (DIV_W+1)'(1);
  assign halfDiv  = divPlus1 >> 1;

  // High half of the period, from the stage that sets the output rate
  assign phaseHigh = bypass ? ((DIV_W+1)'(divCnt) < halfDiv)
                            : ((PCNT_W+1)'(preCnt) < (PCNT_W+1)'(actPre));

  assign periodEnd = dpCtrl.run & divWrap & (bypass | preWrap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actDiv <= DIV_W'(RST_DIV);
      actPre <= PRE_W'(RST_PRE);
    end else if (dpCtrl.load) begin
      actDiv <= newDiv;
      actPre <= newPre;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      preCnt   <= '0;
      cardClkQ <= 1'b0;
    end else begin
      cardClkQ <= dpCtrl.run & phaseHigh;
      if (dpCtrl.load || !dpCtrl.run) begin
        divCnt <= '0;
        preCnt <= '0;
      end else if (divWrap) begin
        divCnt <= '0;
        if (!bypass) preCnt <= preWrap ? '0 : preCnt + PCNT_W'(1);
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  assign cardClk = cardClkQ;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    actDiv != '0);  // R4
  AST_PRE_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    actPre <= PRE_W'(PRE_MAX));  // R4
  AST_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.run |=> !cardClkQ);  // R6
  AST_LOAD_LOW_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtrl.load && dpCtrl.run) |-> !phaseHigh);  // R8
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DIV_W       = 4,
  parameter int PRE_W       = 12,
  parameter int PRE_MAX     = 2048,
  parameter int RST_DIV     = 15,
  parameter int RST_PRE     = 2048,
  parameter int STS_W       = 16,
  parameter int STS_RUN_BIT = 8,
  localparam int RATE_W     = PRE_W + DIV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rateWr,
  input  logic [RATE_W-1:0] rateData,
  input  logic              ctrlWr,
  input  logic [3:0]        ctrlData,
  output logic              cardClk,
  output logic [STS_W-1:0]  statusWord,
  output logic              softRst
);
  dpCtrl_t          dpCtrl;
  logic [DIV_W-1:0] pendDiv;
  logic [PRE_W-1:0] pendPre;
  logic             periodEnd, running;

  sdclk_ctrl #(
    .DIV_W(DIV_W), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX),
    .RST_DIV(RST_DIV), .RST_PRE(RST_PRE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rateWr(rateWr), .rateData(rateData),
    .ctrlWr(ctrlWr), .ctrlData(ctrlData), .periodEnd(periodEnd),
    .dpCtrl(dpCtrl), .pendDiv(pendDiv), .pendPre(pendPre),
    .running(running), .softRst(softRst)
  );

  sdclk_dp #(
    .DIV_W(DIV_W), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX),
    .RST_DIV(RST_DIV), .RST_PRE(RST_PRE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .newDiv(pendDiv),
    .newPre(pendPre), .cardClk(cardClk), .periodEnd(periodEnd)
  );

  always_comb begin
    statusWord              = '0;
    statusWord[STS_RUN_BIT] = running;
  end
endmodule

// File: tb/sdclk_gen_tb.sv
module sdclk_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rateWr = 1'b0;
  logic [15:0] rateData = '0;
  logic        ctrlWr = 1'b0;
  logic [3:0]  ctrlData = '0;
  logic        cardClk;
  logic [15:0] statusWord;
  logic        softRst;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // Pulse-length monitor state
  bit monEn = 0;
  int monA = 0;
  int monB = 0;
  int runLen = 0;
  logic prevClk = 1'b0;

  sdclk_gen u_dut (
    .clk(clk), .rstN(rstN), .rateWr(rateWr), .rateData(rateData),
    .ctrlWr(ctrlWr), .ctrlData(ctrlData), .cardClk(cardClk),
    .statusWord(statusWord), .softRst(softRst)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      summary();
      $finish;
    end
  end

  // R8: every completed high pulse must have a whole length
  always @(negedge clk) begin
    if (cardClk === 1'b1) runLen++;
    else begin
      if (prevClk === 1'b1 && monEn)
        chk(runLen == monA || runLen == monB, "R8 pulse length", runLen, monB);
      runLen = 0;
    end
    prevClk = cardClk;
  end

  function automatic int effDiv(input int d);
    return (d == 0) ? 1 : d;
  endfunction
  function automatic int effPre(input int p);
    return (p > 2048) ? 2048 : p;
  endfunction
  function automatic int expPeriod(input int d, input int p);
    int e = effDiv(d) + 1;
    return (effPre(p) == 0) ? e : e * 2 * effPre(p);
  endfunction
  function automatic int expHigh(input int d, input int p);
    int e = effDiv(d) + 1;
    return (effPre(p) == 0) ? e / 2 : e * effPre(p);
  endfunction

  task automatic wrRate(input int d, input int p);
    rateWr = 1'b1;
    rateData = {p[11:0], d[3:0]};
    @(negedge clk);
    rateWr = 1'b0;
  endtask

  task automatic wrCtrl(input logic [3:0] v);
    ctrlWr = 1'b1;
    ctrlData = v;
    @(negedge clk);
    ctrlWr = 1'b0;
    ctrlData = '0;
  endtask

  task automatic measure(output int hi, output int per, input bit highOnly);
    int guard = 0;
    hi = 0;
    per = 0;
    while (cardClk !== 1'b0 && guard < 100000) begin @(negedge clk); guard++; end
    while (cardClk !== 1'b1 && guard < 100000) begin @(negedge clk); guard++; end
    while (cardClk === 1'b1 && guard < 100000) begin hi++; @(negedge clk); guard++; end
    per = hi;
    if (!highOnly)
      while (cardClk === 1'b0 && guard < 100000) begin per++; @(negedge clk); guard++; end
  endtask

  task automatic stopWait(input string tag, input int limit);
    int n = 0;
    wrCtrl(4'b0001);
    while (statusWord[8] !== 1'b0 && n < limit) begin @(negedge clk); n++; end
    chk(statusWord[8] === 1'b0, tag, statusWord[8], 0);
    repeat (3) @(negedge clk);
    chk(cardClk === 1'b0, tag, cardClk, 0);
  endtask

  task automatic runRate(input int d, input int p, input string tag);
    int hi, per;
    wrRate(d, p);
    wrCtrl(4'b0010);
    measure(hi, per, 0);
    chk(hi == expHigh(d, p), tag, hi, expHigh(d, p));
    chk(per == expPeriod(d, p), tag, per, expPeriod(d, p));
    stopWait(tag, expPeriod(d, p) + 4);
  endtask

  initial begin
    int hi, per, d, p;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(statusWord === 16'h0, "R1 status", statusWord, 0);
    chk(cardClk === 1'b0, "R1 cardClk", cardClk, 0);
    chk(softRst === 1'b0, "R1 softRst", softRst, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 / R1: start with the reset rate, slowest clock
    wrCtrl(4'b0010);
    chk(statusWord === 16'h0100, "R5 running bit", statusWord, 16'h0100);
    chk(cardClk === 1'b0, "R5 first cycle low", cardClk, 0);
    measure(hi, per, 1);
    chk(hi == 32768, "R1 default high phase", hi, 32768);
    stopWait("R6 stop from slowest", 33000);

    // R3: fastest clock, bypassed prescaler
    runRate(1, 0, "R3 fastest");
    runRate(4, 0, "R3 odd divide");
    // R4: clamps
    runRate(0, 3, "R4 divider zero");
    runRate(1, 12'hFFF, "R4 prescaler clamp");
    // R2: field layout, both stages
    runRate(15, 1, "R2 both stages");

    // Random rates
    for (int i = 0; i < 12; i++) begin
      d = int'($urandom % 16);
      p = int'($urandom % 7);
      runRate(d, p, (p == 0) ? "R3 random" : "R2 random");
    end

    // R8: rate change while running, no runt
    wrRate(3, 2);                 // high 8, period 16
    monA = 8; monB = 2; monEn = 1;
    wrCtrl(4'b0010);
    repeat (5) @(negedge clk);
    wrRate(1, 1);                 // high 2, period 4
    repeat (40) @(negedge clk);
    measure(hi, per, 0);
    chk(hi == 2 && per == 4, "R8 new rate live", per, 4);

    // R9: soft reset pulse while running
    wrCtrl(4'b1000);
    chk(softRst === 1'b1, "R9 pulse high", softRst, 1);
    chk(statusWord[8] === 1'b1, "R9 running kept", statusWord[8], 1);
    @(negedge clk);
    chk(softRst === 1'b0, "R9 pulse one cycle", softRst, 0);
    // R9: bit 2 ignored
    wrCtrl(4'b0100);
    chk(statusWord[8] === 1'b1 && softRst === 1'b0, "R9 bit2 ignored", statusWord[8], 1);

    // R6: stop mid-high finishes a whole pulse
    wrRate(3, 2);
    repeat (20) @(negedge clk);
    monA = 8; monB = 8;
    while (cardClk !== 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
    stopWait("R6 stop mid-high", 40);
    monEn = 0;

    // R7: stop and start together
    wrCtrl(4'b0011);
    repeat (3) @(negedge clk);
    chk(statusWord[8] === 1'b0, "R7 stopped stays stopped", statusWord[8], 0);
    wrCtrl(4'b0010);
    repeat (7) @(negedge clk);
    wrCtrl(4'b0011);
    for (int k = 0; k < 24 && statusWord[8] !== 1'b0; k++) @(negedge clk);
    chk(statusWord[8] === 1'b0, "R7 running clock stops", statusWord[8], 0);
    repeat (20) @(negedge clk);
    chk(cardClk === 1'b0, "R7 clock parked", cardClk, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule